// File: doc/BRIEF.md
# OFDM Subcarrier Data/Pilot Assembler

This block assembles one frequency-domain OFDM symbol of 256 carrier slots in front of an IFFT. Mapped data symbols and pilot values reach it on two separate valid/ready input streams, each carrying 22-bit words (signed in-phase half in bits 21:11, signed quadrature half in bits 10:0). Words pass through the block unchanged. The block places them into a 180-carrier middle band that repeats one pilot and then five data carriers. Both 38-slot edge bands read as zero. When the band is full, the block streams all 256 slots in index order on a valid/ready output and marks the final slot.

The two sources run with different latencies. Each input therefore passes through a small realignment queue, so either stream may run ahead of the band writer by up to the queue depth. Each stream applies back-pressure on its own: ready is high only while the frame is filling, that stream still owes words for the frame, and its queue has room. The output follows the usual handshake rules. A beat completes when valid and ready are both high. While valid is high and ready is low, the slot value and the last flag stay unchanged. No input is taken until the final output beat has been accepted. A flag reports when one stream has drifted further ahead of the other than its queue can absorb.

Top module: `ofdm_carrier_assembler`

## Requirements
- R1: After reset, out_valid and align_err are 0 and both dat_ready and pil_ready are 1.
- R2: Output slots 0 to 37 and 218 to 255 carry the value 0.
- R3: Pilot word k (k = 0 to 29, in arrival order within a frame) appears unchanged at output slot 38 + 6k.
- R4: Data word n (n = 0 to 149, in arrival order within a frame) appears unchanged at output slot 38 + 6*(n/5) + (n mod 5) + 1.
- R5: A frame's readout is exactly 256 accepted beats carrying slots 0 to 255 in order, and out_last is 1 on slot 255 only.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_sample and out_last stay unchanged in the next cycle.
- R7: While out_valid is 1, dat_ready and pil_ready are both 0.
- R8: Within one frame, a stream takes exactly its quota (150 data words, 30 pilot words). After that its ready stays 0 until the frame's readout ends.
- R9: The output frame is correct whatever the relative arrival timing of the two streams, including a lead of one stream that fills its queue. With the default depth of 4, pilots sent alone may reach 5 accepted words without raising align_err.
- R10: align_err rises when a stream presents a word while its queue is full and the band writer is stalled waiting on the other stream's empty queue. It stays 1 until the final readout beat is accepted, and is 0 in the cycle after that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dat_valid | input | 1 | Data word offered |
| dat_ready | output | 1 | Data word can be taken |
| dat_sample | input | 22 | Mapped data word, I in 21:11, Q in 10:0 |
| pil_valid | input | 1 | Pilot word offered |
| pil_ready | output | 1 | Pilot word can be taken |
| pil_sample | input | 22 | Pilot word, same packing |
| out_valid | output | 1 | Carrier slot offered downstream |
| out_ready | input | 1 | Downstream takes the slot |
| out_sample | output | 22 | Carrier slot value |
| out_last | output | 1 | Marks slot 255 |
| align_err | output | 1 | Sticky drift error, cleared at frame end |

## Verification
Two things can happen in the same cycle: the final output beat of one frame is accepted, and the next frame's words are already waiting at both inputs. That same cycle also clears a drift error left from the previous frame. The bench provokes this by deliberately raising the error in one frame, then starting the next frame's drivers during that frame's readout so they sit on valid against a low ready. It then checks three things: the error reads 0 right after the last beat, input ready returns, and every slot of the following frame still lands where R3 and R4 place it.

// File: rtl/asm_pkg.sv
package asm_pkg;
  localparam int IQ_W   = 11;
  localparam int WORD_W = 2 * IQ_W;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_t;
endpackage

// File: rtl/asm_align_fifo.sv
module asm_align_fifo #(
  parameter int W     = 22,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/asm_slot_writer.sv
module asm_slot_writer #(
  parameter int NFFT    = 256,
  parameter int NPILOT  = 30,
  parameter int SPACING = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_open,
  input  logic                    pil_avail,
  input  logic                    dat_avail,
  output logic                    pil_pop,
  output logic                    dat_pop,
  output logic                    need_pilot,
  output logic                    need_data,
  output logic                    wr_en,
  output logic [$clog2(NFFT)-1:0] wr_addr,
  output logic                    band_done
);
  localparam int AW    = $clog2(NFFT);
  localparam int BAND  = NPILOT * SPACING;
  localparam int GUARD = (NFFT - BAND) / 2;
  localparam int SW    = $clog2(SPACING);
  localparam logic [AW-1:0] POS_MAX  = AW'(BAND - 1);
  localparam logic [SW-1:0] SLOT_MAX = SW'(SPACING - 1);

  logic [AW-1:0] pos;
  logic [SW-1:0] slot;

  assign need_pilot = frame_open && (slot == '0);
  assign need_data  = frame_open && (slot != '0);
  assign pil_pop    = need_pilot && pil_avail;
  assign dat_pop    = need_data && dat_avail;
  assign wr_en      = pil_pop || dat_pop;
  assign wr_addr    = AW'(GUARD) + pos;
  assign band_done  = wr_en && (pos == POS_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      slot <= '0;
    end else if (wr_en) begin
      if (pos == POS_MAX) begin
        pos  <= '0;
        slot <= '0;
      end else begin
        pos  <= pos + 1'b1;
        slot <= (slot == SLOT_MAX) ? '0 : slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/asm_symbol_ram.sv
module asm_symbol_ram #(
  parameter int W    = 22,
  parameter int NFFT = 256
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NFFT)-1:0] waddr,
  input  logic [W-1:0]            wdata,
  input  logic [$clog2(NFFT)-1:0] raddr,
  output logic [W-1:0]            rdata
);
  logic [W-1:0] cells [NFFT];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/asm_drain.sv
module asm_drain #(
  parameter int W       = 22,
  parameter int NFFT    = 256,
  parameter int NPILOT  = 30,
  parameter int SPACING = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active,
  input  logic                    out_ready,
  input  logic [W-1:0]            rd_word,
  output logic [$clog2(NFFT)-1:0] rd_addr,
  output logic                    out_valid,
  output logic [W-1:0]            out_sample,
  output logic                    out_last,
  output logic                    frame_end
);
  localparam int AW    = $clog2(NFFT);
  localparam int BAND  = NPILOT * SPACING;
  localparam int GUARD = (NFFT - BAND) / 2;
  localparam logic [AW-1:0] BAND_LO = AW'(GUARD);
  localparam logic [AW-1:0] BAND_HI = AW'(GUARD + BAND - 1);
  localparam logic [AW-1:0] IDX_MAX = AW'(NFFT - 1);

  logic [AW-1:0] idx;
  logic          in_band;

  assign rd_addr    = idx;
  assign in_band    = (idx >= BAND_LO) && (idx <= BAND_HI);
  assign out_valid  = active;
  assign out_sample = in_band ? rd_word : '0;
  assign out_last   = active && (idx == IDX_MAX);
  assign frame_end  = out_last && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     idx <= '0;
    else if (active && out_ready)   idx <= (idx == IDX_MAX) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/ofdm_carrier_assembler.sv
module ofdm_carrier_assembler #(
  parameter int IQW         = asm_pkg::IQ_W,
  parameter int NFFT        = 256,
  parameter int NPILOT      = 30,
  parameter int SPACING     = 6,
  parameter int ALIGN_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dat_valid,
  output logic             dat_ready,
  input  logic [2*IQW-1:0] dat_sample,
  input  logic             pil_valid,
  output logic             pil_ready,
  input  logic [2*IQW-1:0] pil_sample,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2*IQW-1:0] out_sample,
  output logic             out_last,
  output logic             align_err
);
  import asm_pkg::*;

  localparam int W     = 2 * IQW;
  localparam int AW    = $clog2(NFFT);
  localparam int NDATA = NPILOT * (SPACING - 1);
  localparam int DCW   = $clog2(NDATA + 1);
  localparam int PCW   = $clog2(NPILOT + 1);

  phase_t         phase;
  logic           filling;
  logic [DCW-1:0] dat_taken;
  logic [PCW-1:0] pil_taken;
  logic           dat_owed, pil_owed;
  logic           dat_push, pil_push;
  logic [W-1:0]   dq_head, pq_head;
  logic           dq_empty, dq_full, pq_empty, pq_full;
  logic           dat_pop, pil_pop, need_pilot, need_data;
  logic           wr_en, band_done, frame_end, err_set;
  logic [AW-1:0]  wr_addr, rd_addr;
  logic [W-1:0]   rd_word;

  assign filling   = (phase == PH_FILL);
  assign dat_owed  = dat_taken < DCW'(NDATA);
  assign pil_owed  = pil_taken < PCW'(NPILOT);
  assign dat_ready = filling && dat_owed && !dq_full;
  assign pil_ready = filling && pil_owed && !pq_full;
  assign dat_push  = dat_valid && dat_ready;
  assign pil_push  = pil_valid && pil_ready;

  // A stream is blocked by its own full queue while the writer starves on the other one.
  assign err_set = (dat_valid && dat_owed && dq_full && need_pilot && pq_empty) ||
                   (pil_valid && pil_owed && pq_full && need_data  && dq_empty);

  asm_align_fifo #(.W(W), .DEPTH(ALIGN_DEPTH)) u_dat_q (
    .clk(clk), .rst_n(rst_n), .push(dat_push), .din(dat_sample),
    .pop(dat_pop), .dout(dq_head), .empty(dq_empty), .full(dq_full));

  asm_align_fifo #(.W(W), .DEPTH(ALIGN_DEPTH)) u_pil_q (
    .clk(clk), .rst_n(rst_n), .push(pil_push), .din(pil_sample),
    .pop(pil_pop), .dout(pq_head), .empty(pq_empty), .full(pq_full));

  asm_slot_writer #(.NFFT(NFFT), .NPILOT(NPILOT), .SPACING(SPACING)) u_writer (
    .clk(clk), .rst_n(rst_n), .frame_open(filling),
    .pil_avail(!pq_empty), .dat_avail(!dq_empty),
    .pil_pop(pil_pop), .dat_pop(dat_pop),
    .need_pilot(need_pilot), .need_data(need_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .band_done(band_done));

  asm_symbol_ram #(.W(W), .NFFT(NFFT)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr),
    .wdata(pil_pop ? pq_head : dq_head),
    .raddr(rd_addr), .rdata(rd_word));

  asm_drain #(.W(W), .NFFT(NFFT), .NPILOT(NPILOT), .SPACING(SPACING)) u_drain (
    .clk(clk), .rst_n(rst_n), .active(phase == PH_DRAIN), .out_ready(out_ready),
    .rd_word(rd_word), .rd_addr(rd_addr), .out_valid(out_valid),
    .out_sample(out_sample), .out_last(out_last), .frame_end(frame_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_FILL;
      dat_taken <= '0;
      pil_taken <= '0;
      align_err <= 1'b0;
    end else begin
      if (band_done)      phase <= PH_DRAIN;
      else if (frame_end) phase <= PH_FILL;

      if (frame_end) begin
        dat_taken <= '0;
        pil_taken <= '0;
      end else begin
        if (dat_push) dat_taken <= dat_taken + 1'b1;
        if (pil_push) pil_taken <= pil_taken + 1'b1;
      end

      if (frame_end)    align_err <= 1'b0;
      else if (err_set) align_err <= 1'b1;
    end
  end
endmodule

// File: rtl/asm_checker.sv
module asm_checker #(
  parameter int W       = 22,
  parameter int NFFT    = 256,
  parameter int NPILOT  = 30,
  parameter int SPACING = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dat_ready,
  input logic         pil_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_sample,
  input logic         out_last,
  input logic         align_err
);
  localparam int AW    = $clog2(NFFT);
  localparam int BAND  = NPILOT * SPACING;
  localparam int GUARD = (NFFT - BAND) / 2;

  logic [AW-1:0] beat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      beat <= '0;
    else if (out_valid && out_ready) beat <= beat + 1'b1;
  end

  AST_DRAIN_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!dat_ready && !pil_ready)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_last))); // R6
  AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && beat == AW'(NFFT - 1))); // R5
  AST_LAST_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && beat == AW'(NFFT - 1)) |-> out_last); // R5
  AST_GUARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (beat < AW'(GUARD) || beat > AW'(GUARD + BAND - 1))) |-> (out_sample == '0)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (align_err && !(out_valid && out_ready && out_last)) |=> align_err); // R10
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !align_err); // R10
endmodule

bind ofdm_carrier_assembler asm_checker #(
  .W(2 * IQW), .NFFT(NFFT), .NPILOT(NPILOT), .SPACING(SPACING)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dat_ready(dat_ready), .pil_ready(pil_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
  .out_last(out_last), .align_err(align_err)
);

// File: tb/ofdm_carrier_assembler_test.sv
`timescale 1ns/1ps
module ofdm_carrier_assembler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dat_valid = 1'b0, pil_valid = 1'b0, out_ready = 1'b1;
  logic [21:0] dat_sample = '0, pil_sample = '0;
  logic        dat_ready, pil_ready, out_valid, out_last, align_err;
  logic [21:0] out_sample;

  int checks = 0, fails = 0;
  logic [29:0] exp_q [$];
  bit          rand_ready = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  bit          held = 1'b0, clear_pending = 1'b0;
  logic [21:0] held_sample;
  logic        held_last;

  always #4 clk = ~clk;

  ofdm_carrier_assembler uut (
    .clk(clk), .rst_n(rst_n),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_sample(dat_sample),
    .pil_valid(pil_valid), .pil_ready(pil_ready), .pil_sample(pil_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
    .out_last(out_last), .align_err(align_err));

  function automatic logic [21:0] dval(int f, int n);
    return {11'(f * 37 + n + 1), 11'(300 - 3 * n)};
  endfunction
  function automatic logic [21:0] pval(int f, int k);
    return {11'(500 + 5 * k + f), 11'(-(k + 1) - f)};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_frame(int f);
    for (int i = 0; i < 256; i++) begin
      logic [21:0] w;
      if (i < 38 || i > 217) w = '0;
      else if ((i - 38) % 6 == 0) w = pval(f, (i - 38) / 6);
      else w = dval(f, ((i - 38) / 6) * 5 + ((i - 38) % 6) - 1);
      exp_q.push_back({i[7:0], w});
    end
  endtask

  task automatic send_dat(logic [21:0] w);
    dat_valid = 1'b1; dat_sample = w;
    forever begin
      if (dat_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    dat_valid = 1'b0;
  endtask

  task automatic send_pil(logic [21:0] w);
    pil_valid = 1'b1; pil_sample = w;
    forever begin
      if (pil_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    pil_valid = 1'b0;
  endtask

  task automatic drive_data(int f, int first);
    for (int n = first; n < 150; n++) send_dat(dval(f, n));
  endtask
  task automatic drive_pilots(int f, int first, int lag);
    repeat (lag) @(negedge clk);
    for (int k = first; k < 30; k++) send_pil(pval(f, k));
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (clear_pending) begin
        check(align_err == 1'b0, "R10 clear after last beat", align_err, 0);
        clear_pending = 1'b0;
      end
      if (held) begin
        check(out_valid && out_sample == held_sample && out_last == held_last,
              "R6 hold under back-pressure", out_sample, held_sample);
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = rand_ready ? (lfsr[0] | lfsr[2]) : 1'b1;
      if (out_valid) check(!dat_ready && !pil_ready, "R7 inputs closed in readout",
                           {dat_ready, pil_ready}, 0);
      held = out_valid && !out_ready;
      held_sample = out_sample;
      held_last = out_last;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected output beat", out_sample, 0);
        end else begin
          logic [29:0] e;
          int idx;
          e = exp_q.pop_front();
          idx = int'(e[29:22]);
          if (idx < 38 || idx > 217)
            check(out_sample == e[21:0], "R2 guard slot", out_sample, e[21:0]);
          else if ((idx - 38) % 6 == 0)
            check(out_sample == e[21:0], "R3 R9 pilot slot", out_sample, e[21:0]);
          else
            check(out_sample == e[21:0], "R4 R9 data slot", out_sample, e[21:0]);
          check(out_last == (idx == 255), "R5 last flag", out_last, (idx == 255));
          if (idx == 255) clear_pending = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !align_err && dat_ready && pil_ready, "R1 reset state",
          {out_valid, align_err, dat_ready, pil_ready}, 4'b0011);

    // Frame 0: both streams back to back, sink always ready
    push_frame(0);
    fork
      begin
        drive_data(0, 0);
        check(dat_ready == 1'b0, "R8 data quota reached", dat_ready, 0);
      end
      drive_pilots(0, 0, 0);
    join
    wait (exp_q.size() == 0);
    @(negedge clk);

    // Frame 1: pilots lag by two cycles, sink stalls pseudo-randomly
    rand_ready = 1'b1;
    push_frame(1);
    fork
      drive_data(1, 0);
      begin
        drive_pilots(1, 0, 2);
        check(pil_ready == 1'b0, "R8 pilot quota reached", pil_ready, 0);
      end
    join
    wait (exp_q.size() == 0);
    @(negedge clk);

    // Frame 2: pilots run ahead until the queue overflows
    push_frame(2);
    for (int k = 0; k < 5; k++) send_pil(pval(2, k));
    @(negedge clk);
    check(align_err == 1'b0, "R9 lead within depth", align_err, 0);
    pil_valid = 1'b1; pil_sample = pval(2, 5);
    repeat (3) @(negedge clk);
    check(align_err == 1'b1, "R10 drift flagged", align_err, 1);
    check(pil_ready == 1'b0, "R10 blocked stream held off", pil_ready, 0);
    fork
      drive_data(2, 0);
      drive_pilots(2, 5, 0);
    join
    @(negedge clk);
    check(align_err == 1'b1, "R10 flag sticky while filling", align_err, 1);

    // Frame 3: offered while frame 2 is still being read out
    push_frame(3);
    fork
      drive_data(3, 0);
      drive_pilots(3, 0, 0);
    join
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    check(align_err == 1'b0, "R10 no error on clean frame", align_err, 0);
    check(!out_valid && dat_ready && pil_ready, "R7 inputs reopen after readout",
          {out_valid, dat_ready, pil_ready}, 3'b011);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule